// File: doc/BRIEF.md
# Mode-0 Parallel Peripheral Interface

This block is a three-port, 8-bit parallel I/O controller driven from a CPU-side register bus. A 2-bit address selects one of four registers: three port data registers (A, B, C) and a control register. The CPU uses a chip select, a read strobe and a write strobe. Data written to a port register is held in that port's output latch. That value reaches the pins when the port is an output. A read returns either the live pins or the latch, depending on the port's direction.

The control register accepts two word formats, and bit 7 selects between them. A configuration word sets the direction of port A, port B, and each nibble of port C. A single-bit word sets or clears one bit of port C without touching the others, which lets software toggle port C lines one at a time. Ports do not use tristate pins. Each one has separate input, output and output-enable buses, and port C has one enable per nibble.

A build parameter picks one of two variants. The standard variant clears every output latch on each configuration write. The reduced variant fixes port B as an input and port C as an output, and keeps the latch contents across configuration writes.

Top module: `ppi_mode0`

## Requirements
- R1: A control write with bit 7 = 0 changes only one bit of the port C latch. Bits 3..1 give the bit index (0–7), and bit 0 gives the new value (1 = set, 0 = clear). Bits 6..4 have no effect, and the other seven port C bits keep their values.
- R2: A control write with bit 7 = 1 sets the port directions, with 1 = input and 0 = output. Bit 4 controls port A, bit 1 port B, bit 0 port C bits 3..0 and bit 3 port C bits 7..4. Each output enable is the inverse of its direction bit: `pc_oe_o[0]` covers the low nibble and `pc_oe_o[1]` the high nibble. Word 0x82 makes port A an output and word 0x92 makes port A an input. Bits 6..5 and bit 2 are ignored.
- R3: In the standard variant (REDUCED = 0), every write with bit 7 = 1 clears the A, B and C latches to zero.
- R4: In the reduced variant (REDUCED = 1), port B is always an input and both nibbles of port C are always outputs, whatever word was written. Writes with bit 7 = 1 leave all latches unchanged.
- R5: Register addresses are 0 = A, 1 = B, 2 = C and 3 = control. A read of a port that is an input returns its pins, and a read of an output port returns its latch. For port C, each nibble makes this choice separately.
- R6: A read of the control register returns the last word written with bit 7 = 1. Single-bit writes do not change it.
- R7: After reset, all latches are zero and the control register reads 0x9B. In the standard variant every port is an input.
- R8: A write takes effect once, on the clock after the write strobe rises while chip select is high. Holding the strobe high writes nothing further, and a strobe edge without chip select writes nothing.
- R9: A value written to a port whose direction is output appears on that port's output bus on the following clock. For example, bit 0 of port B can be driven high or low by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, acts on rising edge |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero unless cs_i and rd_i |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 8 | Port A output enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 8 | Port B output enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_o | output | 2 | Port C output enable, [0] low nibble, [1] high nibble |

## Verification
Single-bit writes are applied to every port C index in turn, first setting and then clearing, with junk placed in the ignored bits. These runs show whether the index is decoded correctly and whether neighbouring bits are disturbed. Configuration words 0x82, 0x92 and 0x98 are written after the latches have been loaded, and both variants run side by side. Comparing the two variants shows the latch clearing of the standard variant against the fixed directions and kept latches of the reduced one. A mixed-direction word on port C, with different pin and latch patterns, shows whether each nibble of a read chooses its source independently. Held strobes and strobes without chip select show whether writes are taken on the edge only.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam logic [7:0] CTRL_RST = 8'h9B;

  localparam logic [1:0] ADDR_A    = 2'd0;
  localparam logic [1:0] ADDR_B    = 2'd1;
  localparam logic [1:0] ADDR_C    = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cl_in;
    logic ch_in;
  } dir_t;
endpackage

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter bit REDUCED = 1'b0,
  parameter int IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [2:0]       port_wr_o,
  output logic             mode_wr_o,
  output logic             bit_wr_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             bit_val_o,
  output logic [7:0]       ctrl_q_o,
  output dir_t             dir_o
);
  logic       wr_q;
  logic       wr_pulse;
  logic [7:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_i;
  end

  assign wr_pulse = cs_i & wr_i & ~wr_q;

  always_comb begin
    port_wr_o = '0;
    if (wr_pulse && addr_i != ADDR_CTRL) port_wr_o[addr_i] = 1'b1;
  end

  assign mode_wr_o = wr_pulse && (addr_i == ADDR_CTRL) &&  wdata_i[7];
  assign bit_wr_o  = wr_pulse && (addr_i == ADDR_CTRL) && !wdata_i[7];
  assign bit_idx_o = wdata_i[IDX_W:1];
  assign bit_val_o = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RST;
    else if (mode_wr_o) ctrl_q <= wdata_i;
  end

  assign ctrl_q_o = ctrl_q;

  // mode-select bits 6..5 and 2 ignored: everything is mode 0
  generate
    if (REDUCED) begin : g_fixed
      assign dir_o = '{a_in: ctrl_q[4], b_in: 1'b1, cl_in: 1'b0, ch_in: 1'b0};
    end else begin : g_prog
      assign dir_o = '{a_in: ctrl_q[4], b_in: ctrl_q[1], cl_in: ctrl_q[0], ch_in: ctrl_q[3]};
    end
  endgenerate

  p_held_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && $past(wr_i)) |-> !mode_wr_o && !bit_wr_o && port_wr_o == '0);
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             bit_en_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             bit_val_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (clr_i)    q <= '0;
    else if (wr_i)     q <= wdata_i;
    else if (bit_en_i) q[bit_idx_i] <= bit_val_i;
  end

  assign q_o = q;

  p_bsr_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !wr_i && !clr_i) |=> ($countones(q ^ $past(q)) <= 1));
endmodule

// File: rtl/ppi_mode0.sv
module ppi_mode0
  import ppi_pkg::*;
#(
  parameter bit REDUCED = 1'b0,
  parameter int PORT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [1:0]        pc_oe_o
);
  localparam int IDX_W = $clog2(PORT_W);
  localparam int HALF  = PORT_W / 2;

  logic [2:0]        port_wr;
  logic              mode_wr, bit_wr, bit_val;
  logic [IDX_W-1:0]  bit_idx;
  logic [7:0]        ctrl_q;
  dir_t              dir;
  logic [PORT_W-1:0] lat [3];
  logic [PORT_W-1:0] c_rd;

  ppi_ctrl #(.REDUCED(REDUCED), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .cs_i, .wr_i, .addr_i, .wdata_i,
    .port_wr_o (port_wr),
    .mode_wr_o (mode_wr),
    .bit_wr_o  (bit_wr),
    .bit_idx_o (bit_idx),
    .bit_val_o (bit_val),
    .ctrl_q_o  (ctrl_q),
    .dir_o     (dir)
  );

  for (genvar p = 0; p < 3; p++) begin : g_lat
    ppi_latch #(.W(PORT_W), .IDX_W(IDX_W)) u_lat (
      .clk_i, .rst_ni,
      .clr_i     (mode_wr && !REDUCED),
      .wr_i      (port_wr[p]),
      .wdata_i   (wdata_i[PORT_W-1:0]),
      .bit_en_i  ((p == 2) ? bit_wr : 1'b0),
      .bit_idx_i (bit_idx),
      .bit_val_i (bit_val),
      .q_o       (lat[p])
    );
  end

  assign pa_o    = lat[0];
  assign pb_o    = lat[1];
  assign pc_o    = lat[2];
  assign pa_oe_o = {PORT_W{~dir.a_in}};
  assign pb_oe_o = {PORT_W{~dir.b_in}};
  assign pc_oe_o = {~dir.ch_in, ~dir.cl_in};

  assign c_rd = {dir.ch_in ? pc_i[PORT_W-1:HALF] : lat[2][PORT_W-1:HALF],
                 dir.cl_in ? pc_i[HALF-1:0]      : lat[2][HALF-1:0]};

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      unique case (addr_i)
        ADDR_A:  rdata_o = dir.a_in ? pa_i : lat[0];
        ADDR_B:  rdata_o = dir.b_in ? pb_i : lat[1];
        ADDR_C:  rdata_o = c_rd;
        default: rdata_o = ctrl_q;
      endcase
    end
  end

  p_dir_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (pa_oe_o == {PORT_W{~$past(wdata_i[4])}}));

  if (!REDUCED) begin : g_chk_std
    p_mode_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_wr |=> (pa_o == '0 && pb_o == '0 && pc_o == '0));
  end else begin : g_chk_red
    p_keep_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_wr && port_wr == '0) |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o)));
  end
endmodule

// File: tb/tb_ppi_mode0.sv
module tb_ppi_mode0;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;

  logic [7:0] rd_s, pa_s, pa_oe_s, pb_s, pb_oe_s, pc_s;
  logic [1:0] pc_oe_s;
  logic [7:0] rd_r, pa_r, pa_oe_r, pb_r, pb_oe_r, pc_r;
  logic [1:0] pc_oe_r;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ppi_mode0 #(.REDUCED(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_s),
    .pa_i(pa_i), .pa_o(pa_s), .pa_oe_o(pa_oe_s),
    .pb_i(pb_i), .pb_o(pb_s), .pb_oe_o(pb_oe_s),
    .pc_i(pc_i), .pc_o(pc_s), .pc_oe_o(pc_oe_s)
  );

  ppi_mode0 #(.REDUCED(1'b1)) dut_red (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_r),
    .pa_i(pa_i), .pa_o(pa_r), .pa_oe_o(pa_oe_r),
    .pb_i(pb_i), .pb_o(pb_r), .pb_oe_o(pb_oe_r),
    .pc_i(pc_i), .pc_o(pc_r), .pc_oe_o(pc_oe_r)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] vs, output logic [7:0] vr);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1;
    vs = rd_s; vr = rd_r;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] s, r;
    chk("R7", "std pa latch", pa_s, 8'h00);
    chk("R7", "std pc latch", pc_s, 8'h00);
    chk("R7", "std pa oe", pa_oe_s, 8'h00);
    chk("R7", "std pb oe", pb_oe_s, 8'h00);
    chk("R7", "std pc oe", {6'b0, pc_oe_s}, 8'h00);
    chk("R4", "red pb oe at reset", pb_oe_r, 8'h00);
    chk("R4", "red pc oe at reset", {6'b0, pc_oe_r}, 8'h03);
    bus_rd(2'd3, s, r);
    chk("R7", "std ctrl read", s, 8'h9B);
    chk("R7", "red ctrl read", r, 8'h9B);
  endtask

  task automatic t_mode_82();
    logic [7:0] s, r;
    bus_wr(2'd3, 8'h82);
    chk("R2", "0x82 pa oe", pa_oe_s, 8'hFF);
    chk("R2", "0x82 pb oe", pb_oe_s, 8'h00);
    chk("R2", "0x82 pc oe", {6'b0, pc_oe_s}, 8'h03);
    bus_rd(2'd3, s, r);
    chk("R6", "ctrl read 0x82", s, 8'h82);
    bus_wr(2'd0, 8'h5A);
    chk("R9", "pa out", pa_s, 8'h5A);
    pa_i = 8'h11;
    bus_rd(2'd0, s, r);
    chk("R5", "read output A gives latch", s, 8'h5A);
  endtask

  task automatic t_bsr();
    logic [7:0] exp = 8'h00;
    logic [7:0] s, r;
    for (int i = 0; i < 8; i++) begin
      bus_wr(2'd3, 8'h70 | 8'(i << 1) | 8'h01);
      exp[i] = 1'b1;
      chk("R1", $sformatf("set bit %0d std", i), pc_s, exp);
      chk("R1", $sformatf("set bit %0d red", i), pc_r, exp);
    end
    for (int i = 0; i < 8; i++) begin
      bus_wr(2'd3, 8'h50 | 8'(i << 1));
      exp[i] = 1'b0;
      chk("R1", $sformatf("clear bit %0d std", i), pc_s, exp);
    end
    bus_wr(2'd3, 8'h07);
    chk("R1", "set bit 3", pc_s, 8'h08);
    bus_rd(2'd3, s, r);
    chk("R6", "bsr leaves ctrl", s, 8'h82);
  endtask

  task automatic t_mode_92();
    logic [7:0] s, r;
    bus_wr(2'd1, 8'h3C);
    bus_wr(2'd2, 8'hE7);
    bus_wr(2'd3, 8'h92);
    chk("R3", "std pa cleared", pa_s, 8'h00);
    chk("R3", "std pb cleared", pb_s, 8'h00);
    chk("R3", "std pc cleared", pc_s, 8'h00);
    chk("R4", "red pa kept", pa_r, 8'h5A);
    chk("R4", "red pb kept", pb_r, 8'h3C);
    chk("R4", "red pc kept", pc_r, 8'hE7);
    chk("R2", "0x92 pa oe std", pa_oe_s, 8'h00);
    chk("R2", "0x92 pa oe red", pa_oe_r, 8'h00);
    pa_i = 8'hC3;
    bus_rd(2'd0, s, r);
    chk("R5", "read input A std", s, 8'hC3);
    chk("R5", "read input A red", r, 8'hC3);
  endtask

  task automatic t_nibbles();
    logic [7:0] s, r;
    bus_wr(2'd3, 8'h98);
    chk("R2", "0x98 pc oe std", {6'b0, pc_oe_s}, 8'h01);
    chk("R4", "0x98 pc oe red", {6'b0, pc_oe_r}, 8'h03);
    chk("R4", "0x98 pb oe red", pb_oe_r, 8'h00);
    bus_wr(2'd2, 8'hA5);
    pc_i = 8'h3C;
    bus_rd(2'd2, s, r);
    chk("R5", "C mixed nibbles std", s, 8'h35);
    chk("R5", "C fixed output red", r, 8'hA5);
  endtask

  task automatic t_pb_bit0();
    logic [7:0] s, r;
    pb_i = 8'h66;
    chk("R2", "0x98 pb oe std", pb_oe_s, 8'hFF);
    bus_wr(2'd1, 8'h01);
    chk("R9", "pb0 high", pb_s, 8'h01);
    bus_wr(2'd1, 8'h00);
    chk("R9", "pb0 low", pb_s, 8'h00);
    bus_rd(2'd1, s, r);
    chk("R5", "read output B std", s, 8'h00);
    chk("R4", "red B reads pins", r, 8'h66);
  endtask

  task automatic t_strobe();
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; addr = 2'd0; wdata = 8'h99;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    chk("R8", "no cs no write", pa_s, 8'h00);
    cs = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 8'h21;
    @(negedge clk);
    wdata = 8'h42;
    @(negedge clk);
    wdata = 8'h84;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    @(negedge clk);
    chk("R8", "held strobe writes once", pb_s, 8'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_82();
    t_bsr();
    t_mode_92();
    t_nibbles();
    t_pb_bit0();
    t_strobe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule